// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a supervision timer that runs on the system clock from the moment reset is released and has no way to be switched off. Software proves it is alive by pulsing an acknowledge strobe before the programmed period runs out. Each acknowledge restarts the period.

When a period runs out with no acknowledge, the block does two things. It raises a sticky interrupt, and it starts a fresh period at once. If that next period also runs out with no acknowledge, the block issues a one-cycle system reset request. It then returns its own counter, reload value, interrupt and stage to their power-on state. The reload value can be written at any time, but a new value only governs the period that begins at the next restart.

The counter holds the remaining count and expires in the cycle where it reads zero. A reload value of N therefore gives a period of N+1 clock cycles.

Top module: `wdg_escalate`

## Requirements
- R1: While reset is held and in the first cycle after its release, `irq` and `rst_req` are both 0.
- R2: The counter starts at `INIT_RELOAD` and counts down on every clock. With no acknowledge, `irq` rises on the (`INIT_RELOAD`+1)-th rising edge after reset release.
- R3: A reload write does not change the period already running. The written value is loaded at the next restart, whether that restart comes from an acknowledge or an expiry, so the next period lasts value+1 cycles.
- R4: A first expiry with no acknowledge sets `irq` and restarts the period from the reload value. `irq` then stays at 1 through acknowledges and later expiries. Only an `irq_clr` pulse or a reset request clears it.
- R5: An expiry that follows an earlier expiry with no acknowledge in between drives `rst_req` high for exactly one cycle.
- R6: An acknowledge reloads the counter and clears the pending stage. The next expiry after it is therefore a first expiry again and raises no reset request.
- R7: An acknowledge in the same cycle in which the counter reads zero takes priority. No expiry is counted.
- R8: In the cycle `rst_req` is high, the counter and the reload value are back at `INIT_RELOAD`, and `irq` and the stage are cleared. The next unacknowledged expiry comes after `INIT_RELOAD`+1 cycles and is a first expiry.
- R9: When `irq_clr` and a first expiry fall in the same cycle, the expiry wins and `irq` ends up at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload_we | input | 1 | Write strobe for the reload value |
| reload_wdata | input | CNT_W | New reload value (period = value+1 cycles) |
| kick | input | 1 | Software acknowledge strobe |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| irq | output | 1 | Sticky watchdog interrupt |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench drives an acknowledge into exactly the cycle where the counter reads zero. A design that lets the expiry win there would raise a spurious interrupt or reset request. It also writes a new reload value in the middle of a period and times the next expiry. A design that loads the value at once would expire early.

An interrupt clear is lined up with a fresh expiry, where a design with the wrong precedence would leave the flag low. After a reset request, the bench times the first expiry to catch a design that keeps the software-written reload value or the pending stage. The stage clearing on acknowledge is checked by letting an expiry follow an acknowledge, which must not escalate.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   typedef enum logic {
      STAGE_FIRST  = 1'b0,
      STAGE_SECOND = 1'b1
   } wdg_stage_e;

endpackage

// File: rtl/wdg_reload_reg.sv
module wdg_reload_reg #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned INIT_RELOAD = 1023
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sys_restart,
   input  logic             we,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] value
);

   localparam logic [CNT_W-1:0] INIT_V = CNT_W'(INIT_RELOAD);

   // The power-on value wins over a write that lands in the reset-request cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           value <= INIT_V;
      else if (sys_restart) value <= INIT_V;
      else if (we)          value <= wdata;
   end

endmodule

// File: rtl/wdg_period_counter.sv
module wdg_period_counter #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned INIT_RELOAD = 1023
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sys_restart,
   input  logic             restart,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             at_zero
);

   localparam logic [CNT_W-1:0] INIT_V = CNT_W'(INIT_RELOAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           count <= INIT_V;
      else if (sys_restart) count <= INIT_V;
      else if (restart)     count <= load_val;
      else                  count <= count - 1'b1;
   end

   assign at_zero = (count == '0);

endmodule

// File: rtl/wdg_escalation.sv
module wdg_escalation
   import wdg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       kick,
   input  logic       at_zero,
   input  logic       irq_clr,
   output logic       expire,
   output logic       fatal,
   output logic       irq,
   output logic       rst_req,
   output wdg_stage_e stage
);

   // An acknowledge in the zero cycle suppresses the expiry.
   assign expire = at_zero & ~kick;
   assign fatal  = expire & (stage == STAGE_SECOND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage   <= STAGE_FIRST;
         irq     <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= fatal;
         if (fatal) begin
            stage <= STAGE_FIRST;
            irq   <= 1'b0;
         end else begin
            if (kick)        stage <= STAGE_FIRST;
            else if (expire) stage <= STAGE_SECOND;
            // A new expiry takes precedence over a clear in the same cycle.
            if (expire)       irq <= 1'b1;
            else if (irq_clr) irq <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/wdg_escalate.sv
module wdg_escalate
   import wdg_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned INIT_RELOAD = 1023
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload_we,
   input  logic [CNT_W-1:0] reload_wdata,
   input  logic             kick,
   input  logic             irq_clr,
   output logic             irq,
   output logic             rst_req
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("wdg_escalate: CNT_W must lie in 2..32");
      end
      if (INIT_RELOAD == 0 || (CNT_W < 32 && INIT_RELOAD >= (64'd1 << CNT_W))) begin : g_bad_init
         $error("wdg_escalate: INIT_RELOAD must be nonzero and fit in CNT_W bits");
      end
   endgenerate

   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] count_q;
   logic             at_zero;
   logic             expire;
   logic             fatal;
   logic             restart;
   wdg_stage_e       stage_q;

   assign restart = kick | expire;

   wdg_reload_reg #(.CNT_W(CNT_W), .INIT_RELOAD(INIT_RELOAD)) u_reload (
      .clk         (clk),
      .rst_n       (rst_n),
      .sys_restart (fatal),
      .we          (reload_we),
      .wdata       (reload_wdata),
      .value       (reload_q)
   );

   wdg_period_counter #(.CNT_W(CNT_W), .INIT_RELOAD(INIT_RELOAD)) u_counter (
      .clk         (clk),
      .rst_n       (rst_n),
      .sys_restart (fatal),
      .restart     (restart),
      .load_val    (reload_q),
      .count       (count_q),
      .at_zero     (at_zero)
   );

   wdg_escalation u_escal (
      .clk     (clk),
      .rst_n   (rst_n),
      .kick    (kick),
      .at_zero (at_zero),
      .irq_clr (irq_clr),
      .expire  (expire),
      .fatal   (fatal),
      .irq     (irq),
      .rst_req (rst_req),
      .stage   (stage_q)
   );

endmodule

// File: rtl/wdg_escalate_chk.sv
module wdg_escalate_chk
   import wdg_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned INIT_RELOAD = 1023
) (
   input logic             clk,
   input logic             rst_n,
   input logic             kick,
   input logic             irq_clr,
   input logic             irq,
   input logic             rst_req,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] reload,
   input wdg_stage_e       stage
);

   localparam logic [CNT_W-1:0] INIT_V = CNT_W'(INIT_RELOAD);

   AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R5

   AST_RST_FROM_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> $past(stage == STAGE_SECOND)); // R5

   AST_KICK_BLOCKS_RST: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> !rst_req); // R7

   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> ($past(irq_clr) || rst_req)); // R4

   AST_FIRST_EXPIRY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && !kick && stage == STAGE_FIRST) |=> irq); // R4

   AST_KICK_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> (count == $past(reload) && stage == STAGE_FIRST)); // R6

   AST_RST_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (count == INIT_V && reload == INIT_V && !irq && stage == STAGE_FIRST)); // R8

endmodule

bind wdg_escalate wdg_escalate_chk #(.CNT_W(CNT_W), .INIT_RELOAD(INIT_RELOAD)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .kick    (kick),
   .irq_clr (irq_clr),
   .irq     (irq),
   .rst_req (rst_req),
   .count   (count_q),
   .reload  (reload_q),
   .stage   (stage_q)
);

// File: tb/wdg_escalate_bench.sv
module wdg_escalate_bench;

   localparam int CNT_W = 16;
   localparam int INIT  = 20;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reload_we = 1'b0;
   logic [CNT_W-1:0] reload_wdata = '0;
   logic             kick = 1'b0;
   logic             irq_clr = 1'b0;
   logic             irq;
   logic             rst_req;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   wdg_escalate #(.CNT_W(CNT_W), .INIT_RELOAD(INIT)) u_wdg_escalate (
      .clk          (clk),
      .rst_n        (rst_n),
      .reload_we    (reload_we),
      .reload_wdata (reload_wdata),
      .kick         (kick),
      .irq_clr      (irq_clr),
      .irq          (irq),
      .rst_req      (rst_req)
   );

   // Behavioural reference: remaining count, reload, pending flag, outputs.
   int m_cnt, m_reload;
   bit m_pend, m_irq, m_rst;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = INIT; m_reload = INIT; m_pend = 0; m_irq = 0; m_rst = 0;
      end else begin
         bit expired;
         expired = (m_cnt == 0) && !kick;
         if (expired && m_pend) begin
            m_cnt = INIT; m_reload = INIT; m_pend = 0; m_irq = 0; m_rst = 1;
         end else begin
            m_rst = 0;
            if (kick || expired) m_cnt = m_reload;
            else                 m_cnt = m_cnt - 1;
            if (reload_we) m_reload = int'(reload_wdata);
            if (kick)         m_pend = 0;
            else if (expired) m_pend = 1;
            if (expired)      m_irq = 1;
            else if (irq_clr) m_irq = 0;
         end
      end
   end

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4", "model irq", irq, m_irq);
         chk("R5", "model rst_req", rst_req, m_rst);
      end
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_kick();
      kick = 1'b1; tick(1); kick = 1'b0;
   endtask

   task automatic pulse_clr();
      irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      tick(3);
      chk("R1", "irq in reset", irq, 1'b0);
      chk("R1", "rst_req in reset", rst_req, 1'b0);
      rst_n = 1'b1;
      chk("R1", "irq after release", irq, 1'b0);
      chk("R1", "rst_req after release", rst_req, 1'b0);
      // First expiry on edge INIT+1.
      tick(INIT);
      chk("R2", "irq before first expiry", irq, 1'b0);
      tick(1);
      chk("R2", "irq at first expiry", irq, 1'b1);
      tick(INIT);
      chk("R5", "rst_req before second expiry", rst_req, 1'b0);
      chk("R4", "irq held through period", irq, 1'b1);
      tick(1);
      chk("R5", "rst_req at second expiry", rst_req, 1'b1);
      tick(1);
      chk("R5", "rst_req single cycle", rst_req, 1'b0);
      chk("R8", "irq cleared by reset request", irq, 1'b0);
      // Mid-period write: old period still runs out at edge 63.
      reload_we = 1'b1; reload_wdata = 16'd5; tick(1); reload_we = 1'b0;
      tick(18);
      chk("R3", "no early expiry after write", irq, 1'b0);
      tick(1);
      chk("R3", "expiry on old period", irq, 1'b1);
      tick(1);
      pulse_kick();
      chk("R4", "irq survives acknowledge", irq, 1'b1);
      tick(5);
      chk("R3", "new period length", rst_req, 1'b0);
      tick(1);
      chk("R6", "expiry after kick is first", rst_req, 1'b0);
      tick(1);
      chk("R6", "no late reset request", rst_req, 1'b0);
      pulse_clr();
      chk("R4", "irq cleared by clear strobe", irq, 1'b0);
      // Pending stage, counter at 3: acknowledge in zero cycle.
      tick(3);
      pulse_kick();
      chk("R7", "kick at zero: no rst_req", rst_req, 1'b0);
      chk("R7", "kick at zero: no irq", irq, 1'b0);
      tick(1);
      chk("R7", "still no rst_req", rst_req, 1'b0);
      // Clear collides with next first expiry.
      tick(4);
      pulse_clr();
      chk("R9", "expiry beats clear", irq, 1'b1);
      tick(5);
      chk("R5", "no rst_req yet", rst_req, 1'b0);
      tick(1);
      chk("R5", "second expiry rst_req", rst_req, 1'b1);
      tick(1);
      tick(19);
      chk("R8", "reload back to power-on value", irq, 1'b0);
      tick(1);
      chk("R8", "expiry after power-on period", irq, 1'b1);
      chk("R8", "first expiry after reset request", rst_req, 1'b0);
      // Mixed traffic against the reference model.
      for (int c = 0; c < 3000; c++) begin
         kick         = ($urandom_range(0, 11) == 0);
         irq_clr      = ($urandom_range(0, 15) == 0);
         reload_we    = ($urandom_range(0, 19) == 0);
         reload_wdata = 16'($urandom_range(2, 12));
         tick(1);
      end
      kick = 1'b0; irq_clr = 1'b0; reload_we = 1'b0;
      tick(2);
      finish_run();
   end

   initial begin
      tick(100000);
      fails++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

endmodule